// File: doc/BRIEF.md
# Serial Dot and Control Write Port

This block is the receiving side of a four-wire serial write port for a driver that lights four 5x7 characters. A host shifts pixel data or configuration bytes in over a data pin qualified by a shift clock and an active-low enable. A select pin, sampled once as the enable goes low, decides whether the bytes go to the 160-bit pixel path or to the 8-bit configuration path. When the enable is raised and the shift clock is low, the shifted bits are committed in one step. Pixel bits go into a parallel pixel latch. Configuration bytes go into one of two 7-bit configuration words, and the top bit of the byte chooses which.

The four port pins are asynchronous to the block clock. They pass through synchronizers and are turned into edge events on the block clock. The decoded brightness, peak-current, run and prescaler fields go to a refresh engine. A cascade output carries either the tail of the active shift path or, during configuration writes, a straight copy of the data pin. That copy lets a chain of drivers take the same configuration byte in eight shift clocks.

Top module: `dsp_serial_port`

## Requirements
- R1: The level of `ser_rs_i` when `ser_ce_n_i` falls selects the target (0 = pixel path, 1 = configuration path); later changes of `ser_rs_i` while `ser_ce_n_i` is low do not redirect the write.
- R2: Each rising `ser_clk_i` while `ser_ce_n_i` is low shifts `ser_din_i` into the selected path. A 160-bit write delivered most significant bit first lands with its bit k at `dot_latch_o[k]`. Configuration bytes are sent bit 7 first. No shifting happens while `ser_ce_n_i` is high.
- R3: The commit happens only once `ser_ce_n_i` is high and `ser_clk_i` is low after a write. If `ser_clk_i` is still high when the enable rises, the outputs keep their old values until the clock falls.
- R4: Byte bit 7 = 0 writes configuration word 0 and bit 7 = 1 writes word 1; the other word keeps its value.
- R5: Word 0 maps bits 3..0 to `pwm_code_o`, bits 5..4 to `peak_code_o` and bit 6 to `run_o` (1 = run, 0 = sleep).
- R6: Word 1 maps bit 0 to `dout_bypass_o` and bit 1 to `prescale8_o`.
- R7: With the bypass bit clear, `ser_dout_o` shows bit 159 of the pixel shift path when the captured select is 0, and bit 7 of the configuration shift path when it is 1.
- R8: With the bypass bit set, `ser_dout_o` follows `ser_din_i` (after synchronization) while a configuration write is open. Pixel writes still show the pixel path tail.
- R9: `rst_ni` low clears both configuration words, so every decoded field reads 0 and the block sleeps. The pixel latch keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock used to sample the port pins |
| rst_ni | input | 1 | Active-low reset, clears configuration state |
| ser_clk_i | input | 1 | Serial shift clock pin |
| ser_ce_n_i | input | 1 | Active-low write enable pin |
| ser_rs_i | input | 1 | Target select pin (0 pixels, 1 configuration) |
| ser_din_i | input | 1 | Serial data pin |
| ser_dout_o | output | 1 | Cascade data output |
| dot_latch_o | output | 160 | Committed pixel bits |
| pwm_code_o | output | 4 | On-time brightness code |
| peak_code_o | output | 2 | Peak current code |
| run_o | output | 1 | 1 = run, 0 = sleep |
| prescale8_o | output | 1 | Divide external oscillator by 8 |
| dout_bypass_o | output | 1 | Cascade output copies data pin during configuration writes |

## Verification
The assertions take for granted that each pin level is held for at least three block clocks. Under that assumption every shift clock edge and every enable edge appears as exactly one clean event after the synchronizers. They also take for granted that data is steady before the shift clock rises, so the synchronized data pairs up with the synchronized clock edge. The stimulus changes one pin at a time and then waits five block clocks before touching any pin again, which keeps every transition inside those limits.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  // Configuration shift path width is fixed by the byte format.
  localparam int CSR_W   = 8;
  localparam int CW0_W   = 7;
  localparam int CW1_W   = 2;
  localparam int WSEL_IX = CSR_W - 1;

  typedef enum logic {
    SEL_DOT  = 1'b0,
    SEL_CTRL = 1'b1
  } sel_e;

  typedef struct packed {
    logic       run;
    logic [1:0] peak;
    logic [3:0] pwm;
  } cw0_t;

  typedef struct packed {
    logic presc8;
    logic bypass;
  } cw1_t;

endpackage

// File: rtl/dsp_pin_sync.sv
module dsp_pin_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[g]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= {STAGES{RST_VAL[g]}};
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/dsp_shift_path.sv
module dsp_shift_path
  import dsp_pkg::*;
#(
  parameter int DOT_BITS = 160
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s_clk_i,
  input  logic                s_ce_n_i,
  input  logic                s_rs_i,
  input  logic                s_din_i,
  output logic [DOT_BITS-1:0] dot_latch_o,
  output logic [CSR_W-1:0]    ctrl_sr_o,
  output logic                ctrl_commit_o,
  output sel_e                sel_o,
  output logic                dot_tail_o
);

  logic                clk_prev_q, ce_prev_q;
  logic                armed_q, armed_d;
  sel_e                sel_q, sel_d;
  logic [CSR_W-1:0]    ctrl_sr_q, ctrl_sr_d;
  logic [DOT_BITS-1:0] dot_sr_q, dot_sr_d;
  logic [DOT_BITS-1:0] dot_latch_q;

  logic clk_rise, ce_fall, shift_en, commit;
  logic dot_shift_en, ctrl_shift_en, dot_commit;

  always_comb begin
    clk_rise      = s_clk_i & ~clk_prev_q;
    ce_fall       = ce_prev_q & ~s_ce_n_i;
    shift_en      = clk_rise & ~s_ce_n_i;
    commit        = armed_q & s_ce_n_i & ~s_clk_i;

    sel_d         = ce_fall ? sel_e'(s_rs_i) : sel_q;
    armed_d       = ce_fall ? 1'b1 : (commit ? 1'b0 : armed_q);

    dot_shift_en  = shift_en & (sel_d == SEL_DOT);
    ctrl_shift_en = shift_en & (sel_d == SEL_CTRL);
    dot_commit    = commit & (sel_q == SEL_DOT);

    dot_sr_d      = {dot_sr_q[DOT_BITS-2:0], s_din_i};
    ctrl_sr_d     = ctrl_shift_en ? {ctrl_sr_q[CSR_W-2:0], s_din_i} : ctrl_sr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_prev_q <= 1'b0;
      ce_prev_q  <= 1'b1;
      armed_q    <= 1'b0;
      sel_q      <= SEL_DOT;
      ctrl_sr_q  <= '0;
    end else begin
      clk_prev_q <= s_clk_i;
      ce_prev_q  <= s_ce_n_i;
      armed_q    <= armed_d;
      sel_q      <= sel_d;
      ctrl_sr_q  <= ctrl_sr_d;
    end
  end

  // Pixel storage is deliberately left out of reset.
  always_ff @(posedge clk_i) begin
    if (dot_shift_en) begin
      dot_sr_q <= dot_sr_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (dot_commit) begin
      dot_latch_q <= dot_sr_q;
    end
  end

  assign dot_latch_o   = dot_latch_q;
  assign ctrl_sr_o     = ctrl_sr_q;
  assign ctrl_commit_o = commit & (sel_q == SEL_CTRL);
  assign sel_o         = sel_q;
  assign dot_tail_o    = dot_sr_q[DOT_BITS-1];

  AST_CE_HIGH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) s_ce_n_i |=> $stable(ctrl_sr_q)) else $error("config path moved with enable high"); // R2
  AST_CTRL_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni) ctrl_shift_en |=> (ctrl_sr_q[0] == $past(s_din_i))) else $error("config path lost data bit"); // R2
  AST_DOT_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !armed_q |=> $stable(dot_latch_q)) else $error("pixel latch changed without a pending write"); // R3
  AST_SINGLE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni) (ctrl_commit_o || dot_commit) |=> !armed_q) else $error("write stayed pending after commit"); // R3

endmodule

// File: rtl/dsp_ctrl_words.sv
module dsp_ctrl_words
  import dsp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [CSR_W-1:0] sr_i,
  output cw0_t             cw0_o,
  output cw1_t             cw1_o
);

  cw0_t w0_q, w0_d;
  cw1_t w1_q, w1_d;

  always_comb begin
    w0_d = w0_q;
    w1_d = w1_q;
    if (commit_i) begin
      if (sr_i[WSEL_IX]) begin
        w1_d = cw1_t'(sr_i[CW1_W-1:0]);
      end else begin
        w0_d = cw0_t'(sr_i[CW0_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w0_q <= '0;
      w1_q <= '0;
    end else begin
      w0_q <= w0_d;
      w1_q <= w1_d;
    end
  end

  assign cw0_o = w0_q;
  assign cw1_o = w1_q;

  AST_WORD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) commit_i |=> ($stable(w0_q) || $stable(w1_q))) else $error("both words written by one commit"); // R4
  AST_WORD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !commit_i |=> ($stable(w0_q) && $stable(w1_q))) else $error("word changed without commit"); // R4

endmodule

// File: rtl/dsp_serial_port.sv
module dsp_serial_port
  import dsp_pkg::*;
#(
  parameter int NUM_CHARS   = 4,
  parameter int CHAR_COLS   = 5,
  parameter int CHAR_ROWS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DOT_BITS   = NUM_CHARS * CHAR_COLS * CHAR_ROWS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ser_clk_i,
  input  logic                ser_ce_n_i,
  input  logic                ser_rs_i,
  input  logic                ser_din_i,
  output logic                ser_dout_o,
  output logic [DOT_BITS-1:0] dot_latch_o,
  output logic [3:0]          pwm_code_o,
  output logic [1:0]          peak_code_o,
  output logic                run_o,
  output logic                prescale8_o,
  output logic                dout_bypass_o
);

  // Synchronizer lanes: [3] data, [2] select, [1] enable, [0] shift clock.
  localparam int         PINS     = 4;
  localparam logic [3:0] PIN_IDLE = 4'b0010;

  logic [PINS-1:0]  pins_raw, pins_s;
  logic [CSR_W-1:0] ctrl_sr;
  logic             ctrl_commit;
  sel_e             sel;
  logic             dot_tail;
  cw0_t             cw0;
  cw1_t             cw1;
  logic             pass_through;

  assign pins_raw = {ser_din_i, ser_rs_i, ser_ce_n_i, ser_clk_i};

  dsp_pin_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  dsp_shift_path #(
    .DOT_BITS(DOT_BITS)
  ) u_path (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .s_clk_i      (pins_s[0]),
    .s_ce_n_i     (pins_s[1]),
    .s_rs_i       (pins_s[2]),
    .s_din_i      (pins_s[3]),
    .dot_latch_o  (dot_latch_o),
    .ctrl_sr_o    (ctrl_sr),
    .ctrl_commit_o(ctrl_commit),
    .sel_o        (sel),
    .dot_tail_o   (dot_tail)
  );

  dsp_ctrl_words u_words (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(ctrl_commit),
    .sr_i    (ctrl_sr),
    .cw0_o   (cw0),
    .cw1_o   (cw1)
  );

  always_comb begin
    pass_through = cw1.bypass & (sel == SEL_CTRL) & ~pins_s[1];
    if (pass_through) begin
      ser_dout_o = pins_s[3];
    end else if (sel == SEL_CTRL) begin
      ser_dout_o = ctrl_sr[WSEL_IX];
    end else begin
      ser_dout_o = dot_tail;
    end
  end

  assign pwm_code_o    = cw0.pwm;
  assign peak_code_o   = cw0.peak;
  assign run_o         = cw0.run;
  assign prescale8_o   = cw1.presc8;
  assign dout_bypass_o = cw1.bypass;

endmodule

// File: tb/dsp_serial_port_test.sv
module dsp_serial_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 5;
  localparam int NB         = 160;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_clk = 1'b0, s_ce_n = 1'b1, s_rs = 1'b0, s_din = 1'b0;
  logic          dout;
  logic [NB-1:0] latch;
  logic [3:0]    pwm;
  logic [1:0]    peak;
  logic          run, presc, bypass;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    int            kind;
    logic [NB-1:0] exp;
    string         req;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_serial_port uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ser_clk_i    (s_clk),
    .ser_ce_n_i   (s_ce_n),
    .ser_rs_i     (s_rs),
    .ser_din_i    (s_din),
    .ser_dout_o   (dout),
    .dot_latch_o  (latch),
    .pwm_code_o   (pwm),
    .peak_code_o  (peak),
    .run_o        (run),
    .prescale8_o  (presc),
    .dout_bypass_o(bypass)
  );

  function automatic logic [NB-1:0] observe(input int kind);
    case (kind)
      0:       return latch;
      1:       return NB'(pwm);
      2:       return NB'(peak);
      3:       return NB'(run);
      4:       return NB'(presc);
      5:       return NB'(bypass);
      default: return NB'(dout);
    endcase
  endfunction

  function automatic logic [NB-1:0] pat_a();
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) p[i] = ((i * 37 + 11) % 7) < 3;
    return p;
  endfunction

  function automatic logic [NB-1:0] pat_b();
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) p[i] = ((i % 3) == 0) ^ ((i / 16) % 2 == 1);
    return p;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [NB-1:0] act;
        it  = sb_q.pop_front();
        act = observe(it.kind);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s field=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int kind, input logic [NB-1:0] exp, input string req);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.req  = req;
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic step();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic shift_bits(input int n, input logic [NB-1:0] bits, input bit last_high);
    for (int i = n - 1; i >= 0; i--) begin
      s_din = bits[i];
      step();
      s_clk = 1'b1;
      step();
      if (i != 0 || !last_high) begin
        s_clk = 1'b0;
        step();
      end
    end
  endtask

  task automatic ser_write(input bit rs, input int n, input logic [NB-1:0] bits,
                           input bit flip_rs, input bit last_high);
    s_clk = 1'b0;
    s_rs  = rs;
    step();
    s_ce_n = 1'b0;
    step();
    if (flip_rs) begin
      s_rs = ~rs;
      step();
    end
    shift_bits(n, bits, last_high);
    s_ce_n = 1'b1;
    step();
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [NB-1:0] a, b;
    a = pat_a();
    b = pat_b();

    repeat (HOLD) @(negedge clk);
    rst_n = 1'b1;
    step();
    expect_val(1, 0, "R9 pwm after reset");
    expect_val(2, 0, "R9 peak after reset");
    expect_val(3, 0, "R9 sleep after reset");
    expect_val(4, 0, "R9 prescale after reset");
    expect_val(5, 0, "R9 bypass after reset");

    // Pixel write: bit k of the word lands at latch index k.
    ser_write(1'b0, NB, a, 1'b0, 1'b0);
    expect_val(0, a, "R2 pixel latch pattern a");
    expect_val(6, NB'(a[NB-1]), "R7 dout pixel tail");
    expect_val(3, 0, "R1 pixel write leaves config");

    // Word 0 = 0_1_10_1101.
    ser_write(1'b1, 8, NB'(8'h6D), 1'b0, 1'b0);
    expect_val(1, NB'(4'hD), "R5 pwm code");
    expect_val(2, NB'(2'd2), "R5 peak code");
    expect_val(3, 1, "R5 run bit");
    expect_val(6, 0, "R7 dout config bit7 low");
    expect_val(0, a, "R1 config write leaves pixels");

    // Word 1 = 1_00000_1_0.
    ser_write(1'b1, 8, NB'(8'h82), 1'b0, 1'b0);
    expect_val(4, 1, "R6 prescale set");
    expect_val(5, 0, "R6 bypass clear");
    expect_val(1, NB'(4'hD), "R4 word0 kept on word1 write");
    expect_val(6, 1, "R7 dout config bit7 high");

    // Select flips after enable falls: still a config write of 0_1_01_0011.
    ser_write(1'b1, 8, NB'(8'h53), 1'b1, 1'b0);
    expect_val(1, NB'(4'h3), "R1 pwm after select flip");
    expect_val(2, NB'(2'd1), "R1 peak after select flip");
    expect_val(0, a, "R1 pixels kept after select flip");
    expect_val(4, 1, "R4 word1 kept on word0 write");

    // Enable rises while shift clock is high: commit waits for clock low.
    ser_write(1'b0, NB, b, 1'b0, 1'b1);
    expect_val(0, a, "R3 no commit while clock high");
    s_clk = 1'b0;
    step();
    step();
    expect_val(0, b, "R3 commit on clock low");

    // Bypass on: word 1 = 1_00000_0_1.
    ser_write(1'b1, 8, NB'(8'h81), 1'b0, 1'b0);
    expect_val(5, 1, "R6 bypass set");
    expect_val(4, 0, "R6 prescale clear");
    s_rs = 1'b1;
    step();
    s_ce_n = 1'b0;
    step();
    s_din = 1'b1;
    step();
    expect_val(6, 1, "R8 dout follows din high");
    s_din = 1'b0;
    step();
    expect_val(6, 0, "R8 dout follows din low");
    s_ce_n = 1'b1;
    step();
    step();
    s_rs = 1'b0;
    step();
    s_ce_n = 1'b0;
    step();
    s_din = ~b[NB-1];
    step();
    expect_val(6, NB'(b[NB-1]), "R8 pixel write keeps tail on dout");
    s_ce_n = 1'b1;
    step();
    step();

    // Reset clears configuration, keeps pixels.
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    expect_val(1, 0, "R9 pwm cleared");
    expect_val(3, 0, "R9 sleep after second reset");
    expect_val(5, 0, "R9 bypass cleared");
    expect_val(0, b, "R9 pixel latch kept");

    step();
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard not drained actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end

endmodule